// File: doc/BRIEF.md
# FIFO Read-Side Output Timing Stage

This block sits between the read port of a FIFO memory and the data output pins. It supports two read timing modes. In standard mode, a word reaches the output register only after an explicit read request, and the status pair reports full and empty. In fall-through mode, the head word is loaded into the output register without any request, and the same status pair reports input-ready and output-ready. The mode is latched while master reset is held and survives partial reset.

The stage issues a pop strobe to the memory whenever it takes the head word. It also handles retransmit: the read pointer is rewound outside this block, and the stage invalidates its output for one cycle so that the head is fetched again. An output enable gates the data outputs to zero when it is low. The memory, the pointers and the write side are outside this block.

Top module: `fwo_stage`

## Requirements
- R1: `mode_sel` is captured into the mode on each clock edge where `mrst` is high (0 = standard, 1 = fall-through). At every other edge, `mode_sel` has no effect on the mode. The mode is standard after `rst_n`.
- R2: An edge with `prst` high clears the output register and the output-valid state, and leaves the mode unchanged.
- R3: After any edge with `mrst` or `prst` high, `q` reads all zeros while `oe` is 1.
- R4: In standard mode, `flag_wr` is 1 exactly when `mem_full` is 1. `flag_rd` is 1 when `mem_empty` is 1, or when the previous edge was a retransmit edge.
- R5: In standard mode, an edge with `rd_en` high and `mem_empty` low pops one word and loads `mem_rdata` into the output register. With `mem_empty` high, `rd_en` causes no pop and the output stays unchanged.
- R6: In fall-through mode, `flag_wr` is the inverse of `mem_full`. `flag_rd` is 1 exactly when the output register holds a valid word.
- R7: In fall-through mode, when the output holds no valid word and `mem_empty` is low, the next edge pops the head word and makes it valid, with or without `rd_en`.
- R8: In fall-through mode, an edge with `rd_en` high and a valid output loads the next word if the memory has one. Otherwise it clears output-ready. `rd_en` has no effect while the output is not valid.
- R9: An edge with `retx` high (and no reset) pops nothing. After it, output-ready reads 0 in fall-through mode and empty reads 1 in standard mode, for one cycle.
- R10: While `oe` is 0, `q` is all zeros. `oe` does not change any stored state.
- R11: `mem_pop` is never high while `mem_empty` is high, and is low during `mrst`, `prst` and `retx` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mrst | input | 1 | Master reset: clears output, captures mode |
| prst | input | 1 | Partial reset: clears output, keeps mode |
| mode_sel | input | 1 | Mode select sampled only during master reset |
| retx | input | 1 | Retransmit request, read pointer rewound outside |
| rd_en | input | 1 | Read enable |
| oe | input | 1 | Output enable, zero-gates `q` when low |
| mem_empty | input | 1 | Memory holds no unread word |
| mem_full | input | 1 | Memory has no free location |
| mem_rdata | input | DATA_W | Head word of the memory |
| mem_pop | output | 1 | Take head word this edge |
| flag_wr | output | 1 | Full (standard) or input-ready (fall-through) |
| flag_rd | output | 1 | Empty (standard) or output-ready (fall-through) |
| q | output | DATA_W | Data outputs |

## Verification
The bench builds the stage with the default 18-bit data width and attaches a memory model with 16 words of capacity. This makes the full condition reachable within a short burst of writes, and keeps a retransmit rewind within the words written since the last reset. Random mode switches under master reset let both flag meanings and both fetch rules be exercised against the same memory traffic. Directed steps cover the following cases:
- a read on an empty memory;
- retransmit in each mode;
- partial reset with the mode input at the opposite level;
- prefetch into an idle output;
- draining the last word.

// File: rtl/fwo_pkg.sv
package fwo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fwo_mode_e;
endpackage

// File: rtl/fwo_mode_latch.sv
module fwo_mode_latch
  import fwo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mrst,
  input  logic      mode_sel,
  output fwo_mode_e mode
);
  fwo_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mrst) mode_d = fwo_mode_e'(mode_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_STD;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R1 / R2: outside master reset the mode never moves
  assert_mode_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mrst |=> $stable(mode_q));
  // R1: master reset captures the select input
  assert_mode_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mrst |=> (mode_q == fwo_mode_e'($past(mode_sel))));
endmodule

// File: rtl/fwo_out_ctrl.sv
module fwo_out_ctrl
  import fwo_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fwo_mode_e         mode,
  input  logic              mrst,
  input  logic              prst,
  input  logic              retx,
  input  logic              rd_en,
  input  logic              mem_empty,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_pop,
  output logic [DATA_W-1:0] q_reg,
  output logic              valid,
  output logic              rt_hold
);
  logic [DATA_W-1:0] q_d;
  logic              valid_d;
  logic              hold_d;
  logic              any_rst;

  assign any_rst = mrst | prst;

  always_comb begin
    mem_pop = 1'b0;
    q_d     = q_reg;
    valid_d = valid;
    hold_d  = 1'b0;
    if (any_rst) begin
      q_d     = '0;
      valid_d = 1'b0;
    end else if (retx) begin
      valid_d = 1'b0;
      hold_d  = 1'b1;
    end else if (mode == MODE_STD) begin
      valid_d = 1'b0;
      if (rd_en && !mem_empty) begin
        mem_pop = 1'b1;
        q_d     = mem_rdata;
      end
    end else begin
      if (!mem_empty && (!valid || rd_en)) begin
        mem_pop = 1'b1;
        q_d     = mem_rdata;
        valid_d = 1'b1;
      end else if (rd_en && valid) begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg   <= '0;
      valid   <= 1'b0;
      rt_hold <= 1'b0;
    end else begin
      q_reg   <= q_d;
      valid   <= valid_d;
      rt_hold <= hold_d;
    end
  end

  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_pop |-> (!mem_empty && !mrst && !prst && !retx));
  assert_reset_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst || prst) |=> (q_reg == '0 && !valid));
  assert_std_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && !any_rst && !(rd_en && !mem_empty)) |=> $stable(q_reg));
  assert_prefetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && !any_rst && !retx && !valid && !mem_empty) |=> valid);
  assert_retx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retx && !any_rst) |=> (!valid && rt_hold));
endmodule

// File: rtl/fwo_flag_mux.sv
module fwo_flag_mux
  import fwo_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  fwo_mode_e         mode,
  input  logic              mem_full,
  input  logic              mem_empty,
  input  logic              valid,
  input  logic              rt_hold,
  input  logic              oe,
  input  logic [DATA_W-1:0] q_reg,
  output logic              flag_wr,
  output logic              flag_rd,
  output logic [DATA_W-1:0] q
);
  always_comb begin
    if (mode == MODE_STD) begin
      flag_wr = mem_full;
      flag_rd = mem_empty | rt_hold;
    end else begin
      flag_wr = ~mem_full;
      flag_rd = valid;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_gate
    assign q[b] = q_reg[b] & oe;
  end
endmodule

// File: rtl/fwo_stage.sv
module fwo_stage
  import fwo_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrst,
  input  logic              prst,
  input  logic              mode_sel,
  input  logic              retx,
  input  logic              rd_en,
  input  logic              oe,
  input  logic              mem_empty,
  input  logic              mem_full,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_pop,
  output logic              flag_wr,
  output logic              flag_rd,
  output logic [DATA_W-1:0] q
);
  fwo_mode_e         mode;
  logic [DATA_W-1:0] q_reg;
  logic              valid;
  logic              rt_hold;

  fwo_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrst     (mrst),
    .mode_sel (mode_sel),
    .mode     (mode)
  );

  fwo_out_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mrst      (mrst),
    .prst      (prst),
    .retx      (retx),
    .rd_en     (rd_en),
    .mem_empty (mem_empty),
    .mem_rdata (mem_rdata),
    .mem_pop   (mem_pop),
    .q_reg     (q_reg),
    .valid     (valid),
    .rt_hold   (rt_hold)
  );

  fwo_flag_mux #(.DATA_W(DATA_W)) u_flags (
    .mode      (mode),
    .mem_full  (mem_full),
    .mem_empty (mem_empty),
    .valid     (valid),
    .rt_hold   (rt_hold),
    .oe        (oe),
    .q_reg     (q_reg),
    .flag_wr   (flag_wr),
    .flag_rd   (flag_rd),
    .q         (q)
  );

  // R6: fall-through output-ready only with a word fetched since the last clear
  assert_fwft_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && !flag_rd && !mem_pop) |=> (!flag_rd || mrst || $past(mrst)));
endmodule

// File: tb/fwo_stage_test.sv
module fwo_stage_test;
  localparam int DW = 18;
  localparam int MD = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, mrst, prst, mode_sel, retx, rd_en, oe, wr;
  logic [DW-1:0] wdata;
  logic mem_empty, mem_full, mem_pop, flag_wr, flag_rd;
  logic [DW-1:0] mem_rdata, q;

  logic [DW-1:0] mem [64];
  int wptr, rptr;

  logic          e_mode, e_v, e_hold;
  logic [DW-1:0] e_q;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign mem_empty = (wptr == rptr);
  assign mem_full  = ((wptr - rptr) == MD);
  assign mem_rdata = mem[rptr & 63];

  fwo_stage #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
    .retx(retx), .rd_en(rd_en), .oe(oe), .mem_empty(mem_empty),
    .mem_full(mem_full), .mem_rdata(mem_rdata), .mem_pop(mem_pop),
    .flag_wr(flag_wr), .flag_rd(flag_rd), .q(q)
  );

  function automatic logic f_pop();
    if (mrst || prst || retx || mem_empty) return 1'b0;
    if (!e_mode) return rd_en;
    return !e_v || rd_en;
  endfunction

  function automatic logic f_fwr();
    return e_mode ? !mem_full : mem_full;
  endfunction

  function automatic logic f_frd();
    return e_mode ? e_v : (mem_empty || e_hold);
  endfunction

  function automatic logic [DW-1:0] f_q();
    return oe ? e_q : '0;
  endfunction

  // memory model and reference state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= 0; rptr <= 0;
      e_mode <= 1'b0; e_v <= 1'b0; e_hold <= 1'b0; e_q <= '0;
    end else begin
      e_hold <= 1'b0;
      if (mrst) e_mode <= mode_sel;
      if (mrst || prst) begin
        wptr <= 0; rptr <= 0; e_q <= '0; e_v <= 1'b0;
      end else begin
        if (retx) begin
          rptr <= 0; e_v <= 1'b0; e_hold <= 1'b1;
        end else if (f_pop()) begin
          rptr <= rptr + 1; e_q <= mem_rdata;
          if (e_mode) e_v <= 1'b1;
        end else if (e_mode && rd_en && e_v) begin
          e_v <= 1'b0;
        end
        if (wr && !mem_full && wptr < 60) begin
          mem[wptr] <= wdata;
          wptr <= wptr + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input logic m, input logic p, input logic ms, input logic rt,
                     input logic rd, input logic o, input logic w, input string req);
    @(negedge clk);
    mrst = m; prst = p; mode_sel = ms; retx = rt; rd_en = rd; oe = o; wr = w;
    wdata = DW'($urandom);
    #2;
    chk(e_mode ? "R6" : "R4", "flag_wr", 32'(flag_wr), 32'(f_fwr()));
    chk(e_mode ? "R6" : "R4", "flag_rd", 32'(flag_rd), 32'(f_frd()));
    chk(req, "q", 32'(q), 32'(f_q()));
    chk("R11", "mem_pop", 32'(mem_pop), 32'(f_pop()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0005_eed1));
    rst_n = 1'b0; mrst = 0; prst = 0; mode_sel = 0; retx = 0; rd_en = 0; oe = 1; wr = 0;
    wdata = '0;
    repeat (2) @(negedge clk);
    #2;
    chk("R3", "reset q", 32'(q), 32'h0);
    chk("R4", "reset empty", 32'(flag_rd), 32'h1);
    rst_n = 1'b1;
    // standard mode
    cyc(1, 0, 0, 0, 0, 1, 0, "R1");
    cyc(0, 0, 1, 0, 1, 1, 0, "R5");   // read while empty, mode_sel toggled
    cyc(0, 0, 1, 0, 1, 1, 0, "R1");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 1, "R4");
    cyc(0, 0, 0, 0, 0, 1, 0, "R5");   // no read: output stays zero
    cyc(0, 0, 0, 0, 1, 1, 0, "R5");
    cyc(0, 0, 0, 0, 1, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 1, 0, "R10");
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 0, 0, 1, 1, "R4");
    cyc(0, 0, 0, 1, 1, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 1, 1, 0, "R5");
    cyc(0, 1, 1, 0, 0, 1, 0, "R2");
    cyc(0, 0, 1, 0, 1, 1, 1, "R3");
    cyc(0, 0, 1, 0, 1, 1, 0, "R2");
    cyc(0, 0, 0, 0, 1, 1, 0, "R5");
    // fall-through mode
    cyc(1, 0, 1, 0, 0, 1, 0, "R1");
    cyc(0, 0, 0, 0, 0, 1, 0, "R3");
    cyc(0, 0, 0, 0, 1, 1, 1, "R8");   // read while not valid
    cyc(0, 0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 0, 0, 1, 0, "R7");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 1, 1, 0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, 1, "R7");
    cyc(0, 0, 0, 1, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 1, 1, 0, "R9");
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0, 0, 1, 1, "R6");
    cyc(0, 1, 0, 0, 0, 1, 0, "R2");
    cyc(0, 0, 0, 0, 0, 1, 1, "R2");
    cyc(0, 0, 0, 0, 0, 1, 0, "R7");
    // random traffic in both modes
    for (int ph = 0; ph < 2; ph++) begin
      cyc(1, 0, ph[0], 0, 0, 1, 0, "R1");
      for (int i = 0; i < 1500; i++) begin
        logic m, p, ms, rt, rd, o, w;
        m  = ($urandom_range(0, 299) == 0);
        p  = ($urandom_range(0, 59) == 0);
        ms = 1'($urandom);
        rt = ($urandom_range(0, 39) == 0);
        rd = ($urandom_range(0, 2) != 0);
        o  = ($urandom_range(0, 7) != 0);
        w  = ($urandom_range(0, 1) != 0);
        cyc(m, p, ms, rt, rd, o, w, e_mode ? "R8" : "R5");
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule